// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Emulator

This block behaves like the digital serial side of a 24-bit delta-sigma converter as a host would see it. A host drives a serial clock, an active-low select and a data line. The block answers on a data output that has an enable, so it can share a line with other devices. The analog part is replaced by a cycle counter of fixed length. The value that a conversion "produces" is whatever was last written through a parallel load port.

The block is always in one of three phases: converting, asleep with a result waiting, or shifting a result out. When the host pulls select low outside the shift phase, the output reads high while a conversion is running and low once a result is waiting. In the shift phase, a 32-bit word leaves MSB first, with one new bit after each falling serial clock edge. At the same time, the data line is sampled on each rising edge to collect configuration bits. A complete frame commits those bits and starts the next conversion. Raising select partway through a frame discards the frame and also starts a conversion.

The select and serial clock pins are brought into the system clock domain through a short synchroniser, and their edges are detected there. All outputs are registered.

Top module: `adc_serial_slave`

## Requirements
- R1: `sdo_en_o` is 0 whenever the synchronised select is high, and 1 whenever it is low.
- R2: While a conversion is running and select is low, `sdo_o` is 1.
- R3: A conversion that ends while select is high leaves the block asleep, with `sdo_o` low. It stays asleep until select falls. Pulling select low after a conversion has ended makes the first output bit 0, which signals that a result is ready.
- R4: The output frame is 32 bits. From first to last it holds: a ready bit (0), a dummy bit (0), the sign bit, 24 result bits, then 5 sub-LSB bits. The last 30 bits are `load_word_i` bits 29 down to 0, so the sign is bit 29 (1 means positive).
- R5: The first frame bit is visible as soon as select falls. Each later bit appears after a falling serial clock edge.
- R6: Data-line bits are sampled on rising serial clock edges only in the shift phase. The first CFG_W bits of a frame form `cfg_o`, with the first bit as its MSB. `cfg_o` changes only when a frame completes. Serial clock activity while select is high is ignored.
- R7: The 32nd rising edge completes the frame and starts a new conversion immediately.
- R8: Raising select after 1 to 31 rising edges aborts the frame. A new conversion starts, and `cfg_o` is unchanged.
- R9: Raising select before any rising edge returns the block to sleep. The next select fall replays the same frame from its first bit.
- R10: A conversion lasts CONV_CYCLES system clock cycles. If it ends while select is low, the block enters the shift phase directly.
- R11: `load_word_i` is captured when `load_valid_i` is high. The captured word is used by the next frame that starts, and a load during a frame does not change that frame.
- R12: After reset the block is converting, `sdo_o` and `sdo_en_o` are 0, and `cfg_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Host serial clock, idles low |
| cs_n_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Host-to-block serial data |
| load_valid_i | input | 1 | Strobe for the next result word |
| load_word_i | input | WORD_W (30) | Sign, result and sub-LSB bits |
| sdo_o | output | 1 | Serial data/status output |
| sdo_en_o | output | 1 | Output enable; 0 means high impedance |
| cfg_o | output | CFG_W (8) | Configuration bits from the last complete frame |

## Verification
The assertions check the following on every cycle:
- The phase moves the way the select and clock edges demand: into sleep on an early release, into conversion on an abort or a full frame.
- `sdo_o` reads high while converting and low while asleep.
- `cfg_o` holds still except on a frame completion.
- No conversion outlasts its cycle budget.

Some behaviours only the bench's scenarios can show:
- The exact bit order and content of a frame.
- The use of the word loaded before, not during, a frame.
- The replay of a frame after an early release.
- The timing of the ready transition when a conversion ends with select held low.

// File: rtl/adc_pkg.sv
package adc_pkg;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_DATA  = 2'd2
  } adc_state_e;

endpackage

// File: rtl/adc_sync_edge.sv
module adc_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= {(STAGES+1){RST_VAL}};
    else     pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
  assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
  parameter int CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic done_o
);

  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign done_o = run_q && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (done_o) run_q <= 1'b0;
      else        cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] frame_i,
  input  logic         shift_i,
  output logic         msb_o
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)          sh_q <= '0;
    else if (load_i)  sh_q <= frame_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign msb_o = sh_q[W-1];

endmodule

// File: rtl/adc_cfg_capture.sv
module adc_cfg_capture #(
  parameter int CFG_W = 8,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             sdi_i,
  input  logic             commit_i,
  output logic [CFG_W-1:0] cfg_o
);

  logic [CFG_W-1:0] sh_q;
  logic [CFG_W-1:0] cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q  <= '0;
      cfg_q <= '0;
    end else begin
      if (clr_i)
        sh_q <= '0;
      else if (sample_i && (int'(idx_i) < CFG_W))
        sh_q <= {sh_q[CFG_W-2:0], sdi_i};
      if (commit_i)
        cfg_q <= sh_q;
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/adc_serial_slave.sv
module adc_serial_slave
  import adc_pkg::*;
#(
  parameter int RES_W       = 24,
  parameter int SUB_W       = 5,
  parameter int CFG_W       = 8,
  parameter int CONV_CYCLES = 64,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = 1 + RES_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_i,
  input  logic              cs_n_i,
  input  logic              sdi_i,
  input  logic              load_valid_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic              sdo_o,
  output logic              sdo_en_o,
  output logic [CFG_W-1:0]  cfg_o
);

  localparam int FRAME_W = WORD_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_RISE = CNT_W'(FRAME_W - 1);

  // synchronised pins
  logic cs_n_lvl, cs_rise, cs_fall, cs_low_s;
  logic sck_lvl, sck_rise, sck_fall;

  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst(rst), .d_i(cs_n_i),
    .level_o(cs_n_lvl), .rise_o(cs_rise), .fall_o(cs_fall)
  );

  adc_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst(rst), .d_i(sck_i),
    .level_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall)
  );

  assign cs_low_s = ~cs_n_lvl;

  // control state
  adc_state_e       state_q, state_d;
  logic [CNT_W-1:0] rise_cnt;
  logic [WORD_W-1:0] pending_q;
  logic             tmr_start, tmr_done;
  logic             enter_data, frame_done, sample_en, shift_en, shift_msb;
  logic             sdo_q, sdo_en_q;

  assign sample_en  = (state_q == ST_DATA) && sck_rise && !cs_rise;
  assign shift_en   = (state_q == ST_DATA) && sck_fall && !sck_lvl && !cs_rise;
  assign frame_done = sample_en && (rise_cnt == LAST_RISE);

  always_comb begin
    state_d    = state_q;
    tmr_start  = 1'b0;
    enter_data = 1'b0;
    unique case (state_q)
      ST_CONV: begin
        if (tmr_done) begin
          if (cs_low_s) begin
            state_d    = ST_DATA;
            enter_data = 1'b1;
          end else begin
            state_d = ST_SLEEP;
          end
        end
      end
      ST_SLEEP: begin
        if (cs_fall) begin
          state_d    = ST_DATA;
          enter_data = 1'b1;
        end
      end
      ST_DATA: begin
        if (cs_rise) begin
          if (rise_cnt == '0) begin
            state_d = ST_SLEEP;
          end else begin
            state_d   = ST_CONV;
            tmr_start = 1'b1;
          end
        end else if (frame_done) begin
          state_d   = ST_CONV;
          tmr_start = 1'b1;
        end
      end
      default: begin
        state_d   = ST_CONV;
        tmr_start = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CONV;
      rise_cnt  <= '0;
      pending_q <= '0;
      sdo_q     <= 1'b0;
      sdo_en_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (enter_data)     rise_cnt <= '0;
      else if (sample_en) rise_cnt <= rise_cnt + 1'b1;
      if (load_valid_i)   pending_q <= load_word_i;
      sdo_en_q <= cs_low_s;
      sdo_q    <= cs_low_s &&
                  ((state_q == ST_DATA) ? shift_msb : (state_q == ST_CONV));
    end
  end

  adc_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start_i(tmr_start), .done_o(tmr_done)
  );

  adc_frame_shift #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst(rst), .load_i(enter_data),
    .frame_i({2'b00, pending_q}), .shift_i(shift_en), .msb_o(shift_msb)
  );

  adc_cfg_capture #(.CFG_W(CFG_W), .IDX_W(CNT_W)) u_cfg (
    .clk(clk), .rst(rst), .clr_i(enter_data), .sample_i(sample_en),
    .idx_i(rise_cnt), .sdi_i(sdi_i), .commit_i(frame_done), .cfg_o(cfg_o)
  );

  assign sdo_o    = sdo_q;
  assign sdo_en_o = sdo_en_q;

endmodule

// File: rtl/adc_serial_slave_chk.sv
module adc_serial_slave_chk
  import adc_pkg::*;
#(
  parameter int CFG_W       = 8,
  parameter int CNT_W       = 6,
  parameter int FRAME_W     = 32,
  parameter int CONV_CYCLES = 64
) (
  input logic             clk,
  input logic             rst,
  input adc_state_e       state_q,
  input logic             cs_low_s,
  input logic             cs_rise,
  input logic             cs_fall,
  input logic [CNT_W-1:0] rise_cnt,
  input logic             frame_done,
  input logic             sdo_o,
  input logic [CFG_W-1:0] cfg_o
);

  localparam int TW = $clog2(CONV_CYCLES + 1) + 1;
  logic [TW-1:0] conv_len_q;

  always_ff @(posedge clk) begin
    if (rst)                     conv_len_q <= '0;
    else if (state_q == ST_CONV) conv_len_q <= conv_len_q + 1'b1;
    else                         conv_len_q <= '0;
  end

  // R2: busy flag while converting with select low
  p_busy_high_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && cs_low_s) |=> sdo_o);

  // R3: sleep holds until select falls, output low meanwhile
  p_sleep_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !cs_fall) |=> (state_q == ST_SLEEP));
  p_sleep_low_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP) |=> !sdo_o);

  // R6: configuration only moves on frame completion
  p_cfg_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !frame_done |=> $stable(cfg_o));

  // R7: full frame starts a conversion
  p_frame_conv_r7: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> (state_q == ST_CONV));

  // R8: mid-frame release aborts into conversion
  p_abort_conv_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && cs_rise && rise_cnt != '0) |=> (state_q == ST_CONV));

  // R9: release before the first rising edge returns to sleep
  p_early_sleep_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DATA && cs_rise && rise_cnt == '0) |=> (state_q == ST_SLEEP));

  // R10: conversion never outlasts its budget
  p_conv_len_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV) |-> (conv_len_q < TW'(CONV_CYCLES)));

endmodule

bind adc_serial_slave adc_serial_slave_chk #(
  .CFG_W(CFG_W), .CNT_W(CNT_W), .FRAME_W(FRAME_W), .CONV_CYCLES(CONV_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .state_q(state_q), .cs_low_s(cs_low_s),
  .cs_rise(cs_rise), .cs_fall(cs_fall), .rise_cnt(rise_cnt),
  .frame_done(frame_done), .sdo_o(sdo_o), .cfg_o(cfg_o)
);

// File: tb/tb_adc_serial_slave.sv
module tb_adc_serial_slave;

  localparam int CONV = 64;
  localparam int H    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        ld_v = 1'b0;
  logic [29:0] ld_w = '0;
  logic        sdo, sdo_en;
  logic [7:0]  cfg;

  always #4 clk = ~clk;

  adc_serial_slave #(.CONV_CYCLES(CONV)) dut (
    .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .sdi_i(sdi),
    .load_valid_i(ld_v), .load_word_i(ld_w),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .cfg_o(cfg)
  );

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  smp;
  int    checks = 0;
  int    failures = 0;

  // monitor: pop and compare
  initial begin
    forever begin
      @(smp);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = {31'b0, sdo};
          1:       act = {31'b0, sdo_en};
          default: act = {24'b0, cfg};
        endcase
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(input int kind, input logic [31:0] v, input string req);
    item_t it;
    it.kind = kind; it.exp = v; it.req = req;
    q.push_back(it);
    ->smp;
    #0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_frame(input logic [31:0] frame, input logic [31:0] pat,
                            input int nbits, input string req);
    for (int i = 0; i < nbits; i++) begin
      expect_v(0, {31'b0, frame[31-i]}, req);
      sdi = pat[31-i];
      sck = 1'b1;
      wait_clk(H);
      if (i < nbits - 1) begin
        sck = 1'b0;
        wait_clk(H);
      end
    end
  endtask

  task automatic load(input logic [29:0] w);
    ld_w = w; ld_v = 1'b1;
    wait_clk(1);
    ld_v = 1'b0;
  endtask

  localparam logic [29:0] W1 = 30'h2B4C_1E35;
  localparam logic [29:0] W2 = 30'h0F0F_A5A3;
  localparam logic [31:0] P1 = 32'hC5A0_0001;
  localparam logic [31:0] P2 = 32'h3C00_0000;
  localparam logic [31:0] P3 = 32'h9600_0000;

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(1);
    expect_v(1, 0, "R12 enable after reset");
    expect_v(0, 0, "R12 sdo after reset");
    expect_v(2, 0, "R12 cfg after reset");
    load(W1);
    // select low during the first conversion
    cs_n = 1'b0; wait_clk(H);
    expect_v(1, 1, "R1 enable with select low");
    expect_v(0, 1, "R2 busy during conversion");
    cs_n = 1'b1; wait_clk(H);
    expect_v(1, 0, "R1 enable with select high");
    wait_clk(80);
    expect_v(0, 0, "R3 sleep output low");
    // clock activity while deselected must be ignored
    sdi = 1'b1;
    for (int k = 0; k < 4; k++) begin
      sck = 1'b1; wait_clk(H); sck = 1'b0; wait_clk(H);
    end
    expect_v(2, 0, "R6 cfg unchanged by deselected clocks");
    // full frame, load of a new word during it
    cs_n = 1'b0; wait_clk(2);
    load(W2);
    wait_clk(H);
    read_frame({2'b00, W1}, P1, 32, "R4 R5 R11 frame W1");
    expect_v(0, 1, "R7 new conversion after full frame");
    expect_v(2, {24'b0, P1[31:24]}, "R6 cfg committed");
    sck = 1'b0;
    wait_clk(CONV - 16);
    expect_v(0, 1, "R10 still converting");
    wait_clk(16);
    expect_v(0, 0, "R10 R3 ready bit with select held low");
    cs_n = 1'b1; wait_clk(H);
    expect_v(1, 0, "R1 released");
    // aborted frame
    cs_n = 1'b0; wait_clk(H);
    read_frame({2'b00, W2}, P2, 10, "R5 partial frame W2");
    cs_n = 1'b1; wait_clk(2);
    sck = 1'b0; wait_clk(H);
    expect_v(2, {24'b0, P1[31:24]}, "R8 cfg kept after abort");
    cs_n = 1'b0; wait_clk(H);
    expect_v(0, 1, "R8 conversion restarted by abort");
    cs_n = 1'b1;
    wait_clk(100);
    // early release then replay
    cs_n = 1'b0; wait_clk(H);
    expect_v(0, 0, "R3 R9 ready bit");
    cs_n = 1'b1; wait_clk(H);
    expect_v(0, 0, "R9 still asleep");
    cs_n = 1'b0; wait_clk(H);
    read_frame({2'b00, W2}, P3, 32, "R9 R4 replayed frame W2");
    expect_v(2, {24'b0, P3[31:24]}, "R6 cfg from replayed frame");
    cs_n = 1'b1; sck = 1'b0;
    wait_clk(H);
    expect_v(1, 0, "R1 final release");
    wait_clk(4);
    if (q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard residue actual=%0d expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule